// File: doc/BRIEF.md
# Header-Payload Stream Concatenator

This block joins two ready/valid framed streams into one outgoing packet. The header input carries one block of one or more words and is emitted first. The payload input carries a block ending in an end-of-packet word and is emitted after the header. The result is a single packet with one start marker on its first word and one end marker on its last word.

The seam between the two parts is placed at symbol granularity. If the header's final word carries unused symbols, those slots are filled with the first payload symbols. Every later payload word is then shifted by the same number of symbols. A residue register carries the symbols that overflow from one word into the next, and the output empty count is recomputed at the end. A phase machine with three states controls the flow. PH_HEAD forwards or absorbs header words. PH_BODY forwards payload words merged with the residue. PH_TAIL emits one leftover word when the residue outlives the payload.

The transitions are as follows. HEAD_DONE goes from PH_HEAD to PH_BODY when the header end word is accepted. BODY_DONE goes from PH_BODY to PH_HEAD when the payload end fits in the current word. BODY_SPILL goes from PH_BODY to PH_TAIL when the payload end overflows. TAIL_DONE goes from PH_TAIL to PH_HEAD when the leftover word is taken.

Top module: `hp_concat`

## Requirements
- R1: Header words leave first. The output start marker appears only on the first word of each packet. The header's end marker is never forwarded, and no start marker is taken from the payload.
- R2: The payload input is not ready until the header end word has been accepted. The header input is not ready from that point until the packet's final word has left. The two ready outputs are never high together.
- R3: Symbol s of a word (s = 0 first) occupies bits [DATA_W-1-s*SYM_W -: SYM_W], and empty counts unused symbols at the least significant end. When the header ends with E unused symbols (E > 0), the first payload symbols fill those E slots, and later payload symbols follow contiguously with no gap.
- R4: The final output word carries empty = (E + P) mod NSYM, where P is the payload end word's empty count and NSYM = DATA_W/SYM_W. Every non-final output word has empty 0.
- R5: When E > 0 and E + P < NSYM, one extra output word is produced after the payload end word has been accepted. The payload end marker then moves to that extra word.
- R6: When E = 0, payload words pass through unshifted with their own empty count on the last word.
- R7: While out_ready is low, neither input is ready, no internal phase or residue state changes, and a presented output word stays unchanged.
- R8: Unused symbol slots of the final output word are driven to zero, whatever the inputs carry there.
- R9: After reset the output is not valid, the payload input is not ready, and the header input is ready whenever out_ready is high.
- R10: A single-word header with E > 0 is absorbed without being emitted on its own, and the start marker moves to the first merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header word accepted when high with valid |
| hdr_data | input | DATA_W | Header word |
| hdr_sop | input | 1 | First header word |
| hdr_eop | input | 1 | Last header word |
| hdr_empty | input | EMPTY_W | Unused symbols in last header word |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Payload word accepted when high with valid |
| pay_data | input | DATA_W | Payload word |
| pay_eop | input | 1 | Last payload word |
| pay_empty | input | EMPTY_W | Unused symbols in last payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_empty | output | EMPTY_W | Unused symbols in last output word |

## Verification
A wrong residue count shows up on the very next payload word taken after the header seam. The symbols come out rotated, or stale symbols are OR-ed into them, and the scoreboard's word compare catches this on that transfer. A phase error shows in one of three ways: both ready outputs high in the same cycle, a payload word accepted ahead of a header word, or a missing or doubled end word. Each of these is visible within the packet where it happens. The bench runs random backpressure and input gaps against packets that cover every relation between E and P, including the wrap and spill cases.

// File: rtl/hp_concat_pkg.sv
package hp_concat_pkg;

    typedef enum logic [1:0] {
        PH_HEAD = 2'd0,
        PH_BODY = 2'd1,
        PH_TAIL = 2'd2
    } phase_t;

endpackage

// File: rtl/hp_sym_mask.sv
module hp_sym_mask #(
    parameter int DATA_W = 32,
    parameter int SYM_W  = 8,
    parameter int KW     = 3
) (
    input  logic [KW-1:0]     keep,
    output logic [DATA_W-1:0] mask
);
    localparam int NSYM = DATA_W / SYM_W;

    // One lane per symbol: a lane stays open when its index is below keep.
    for (genvar i = 0; i < NSYM; i++) begin : g_lane
        assign mask[DATA_W-1-i*SYM_W -: SYM_W] = {SYM_W{(KW'(i) < keep)}};
    end

endmodule

// File: rtl/hp_seam_shift.sv
module hp_seam_shift #(
    parameter int DATA_W = 32,
    parameter int SYM_W  = 8,
    parameter int CW     = 2
) (
    input  logic [DATA_W-1:0] carry_q,
    input  logic [DATA_W-1:0] word,
    input  logic [CW-1:0]     held,
    output logic [DATA_W-1:0] joined,
    output logic [DATA_W-1:0] carry_d
);
    localparam int NSYM = DATA_W / SYM_W;
    localparam int SH_W = $clog2(DATA_W + 1) + 1;

    logic [SH_W-1:0] sh_in;
    logic [SH_W-1:0] sh_out;

    // held symbols sit left-aligned in carry_q; the new word slides right behind them
    always_comb begin
        sh_in   = SH_W'(held) * SH_W'(SYM_W);
        sh_out  = (SH_W'(NSYM) - SH_W'(held)) * SH_W'(SYM_W);
        joined  = carry_q | (word >> sh_in);
        carry_d = word << sh_out;
    end

endmodule

// File: rtl/hp_concat.sv
module hp_concat
    import hp_concat_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SYM_W   = 8,
    parameter int EMPTY_W = ((DATA_W / SYM_W) > 1) ? $clog2(DATA_W / SYM_W) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [DATA_W-1:0]  hdr_data,
    input  logic               hdr_sop,
    input  logic               hdr_eop,
    input  logic [EMPTY_W-1:0] hdr_empty,
    input  logic               pay_valid,
    output logic               pay_ready,
    input  logic [DATA_W-1:0]  pay_data,
    input  logic               pay_eop,
    input  logic [EMPTY_W-1:0] pay_empty,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty
);
    localparam int NSYM = DATA_W / SYM_W;
    localparam int KW   = EMPTY_W + 1;
    localparam logic [KW-1:0] FULL_K = KW'(NSYM);

    phase_t             phase_q, phase_d;
    logic [DATA_W-1:0]  carry_q, carry_d;
    logic [EMPTY_W-1:0] held_q,  held_d;
    logic               sop_pend_q, sop_pend_d;

    logic               hdr_partial;
    logic               pay_spill;
    logic               hdr_fire, pay_fire;
    logic [DATA_W-1:0]  joined, shift_carry;
    logic [KW-1:0]      hdr_keep, out_keep;
    logic [DATA_W-1:0]  hdr_mask, out_mask;
    logic [DATA_W-1:0]  raw_data;

    assign hdr_partial = hdr_eop && (hdr_empty != '0);
    assign pay_spill   = pay_eop && (held_q > pay_empty);
    assign hdr_fire    = hdr_valid && hdr_ready;
    assign pay_fire    = pay_valid && pay_ready;
    assign hdr_keep    = FULL_K - {1'b0, hdr_empty};
    assign out_keep    = out_eop ? (FULL_K - {1'b0, out_empty}) : FULL_K;
    assign out_data    = raw_data & out_mask;

    hp_seam_shift #(.DATA_W(DATA_W), .SYM_W(SYM_W), .CW(EMPTY_W)) u_shift (
        .carry_q (carry_q),
        .word    (pay_data),
        .held    (held_q),
        .joined  (joined),
        .carry_d (shift_carry)
    );

    hp_sym_mask #(.DATA_W(DATA_W), .SYM_W(SYM_W), .KW(KW)) u_hdr_mask (
        .keep (hdr_keep),
        .mask (hdr_mask)
    );

    hp_sym_mask #(.DATA_W(DATA_W), .SYM_W(SYM_W), .KW(KW)) u_out_mask (
        .keep (out_keep),
        .mask (out_mask)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_HEAD;
            carry_q    <= '0;
            held_q     <= '0;
            sop_pend_q <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            carry_q    <= carry_d;
            held_q     <= held_d;
            sop_pend_q <= sop_pend_d;
        end
    end

    // Transitions: HEAD_DONE, BODY_DONE, BODY_SPILL, TAIL_DONE
    always_comb begin
        phase_d    = phase_q;
        carry_d    = carry_q;
        held_d     = held_q;
        sop_pend_d = sop_pend_q;
        unique case (phase_q)
            PH_HEAD: begin
                if (hdr_fire && hdr_eop) begin
                    phase_d = PH_BODY;
                    if (hdr_partial) begin
                        carry_d    = hdr_data & hdr_mask;
                        held_d     = EMPTY_W'(hdr_keep);
                        sop_pend_d = hdr_sop;
                    end else begin
                        carry_d    = '0;
                        held_d     = '0;
                        sop_pend_d = 1'b0;
                    end
                end
            end
            PH_BODY: begin
                if (pay_fire) begin
                    sop_pend_d = 1'b0;
                    carry_d    = shift_carry;
                    if (pay_eop && pay_spill) begin
                        phase_d = PH_TAIL;
                        held_d  = held_q - pay_empty;
                    end else if (pay_eop) begin
                        phase_d = PH_HEAD;
                        held_d  = '0;
                        carry_d = '0;
                    end
                end
            end
            PH_TAIL: begin
                if (out_ready) begin
                    phase_d = PH_HEAD;
                    held_d  = '0;
                    carry_d = '0;
                end
            end
            default: phase_d = PH_HEAD;
        endcase
    end

    // Outputs
    always_comb begin
        hdr_ready = 1'b0;
        pay_ready = 1'b0;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_empty = '0;
        raw_data  = '0;
        unique case (phase_q)
            PH_HEAD: begin
                hdr_ready = out_ready;
                out_valid = hdr_valid && !hdr_partial;
                out_sop   = hdr_sop;
                raw_data  = hdr_data;
            end
            PH_BODY: begin
                pay_ready = out_ready;
                out_valid = pay_valid;
                out_sop   = sop_pend_q;
                raw_data  = joined;
                out_eop   = pay_eop && !pay_spill;
                out_empty = (pay_eop && !pay_spill) ? (pay_empty - held_q) : '0;
            end
            PH_TAIL: begin
                out_valid = 1'b1;
                out_eop   = 1'b1;
                raw_data  = carry_q;
                out_empty = EMPTY_W'(FULL_K - {1'b0, held_q});
            end
            default: ;
        endcase
    end

    // Assertions
    assert_excl_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !(hdr_ready && pay_ready));

    assert_head_closed_R2: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_ready && hdr_eop) |=> !hdr_ready);

    assert_hold_state_R7: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> ($stable(phase_q) && $stable(held_q) && $stable(carry_q)));

    assert_mid_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> (out_empty == '0));

    assert_end_rearm_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eop) |=> (phase_q == PH_HEAD && held_q == '0));

    assert_no_mid_sop_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eop) |=> !(out_valid && out_sop));

endmodule

// File: tb/hp_concat_tb.sv
module hp_concat_tb;
    localparam int DATA_W = 32;
    localparam int SYM_W  = 8;
    localparam int NSYM   = DATA_W / SYM_W;
    localparam int EW     = 2;

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic              sop;
        logic              eop;
        logic [EW-1:0]     e;
    } word_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hdr_valid = 1'b0, hdr_sop = 1'b0, hdr_eop = 1'b0;
    logic [DATA_W-1:0] hdr_data = '0;
    logic [EW-1:0]     hdr_empty = '0;
    logic              hdr_ready;
    logic              pay_valid = 1'b0, pay_eop = 1'b0;
    logic [DATA_W-1:0] pay_data = '0;
    logic [EW-1:0]     pay_empty = '0;
    logic              pay_ready;
    logic              out_valid, out_sop, out_eop;
    logic              out_ready = 1'b1;
    logic [DATA_W-1:0] out_data;
    logic [EW-1:0]     out_empty;

    int     n_tests = 0;
    int     n_fail  = 0;
    bit     bp_on   = 1'b0;
    bit     gap_on  = 1'b0;
    logic [7:0] sym_ctr = 8'h01;

    word_t  hq[$];
    word_t  pq[$];
    word_t  exp_q[$];
    string  tag_q[$];

    always #4 clk = ~clk;

    hp_concat #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_dut (
        .clk(clk), .rst(rst),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
        .hdr_sop(hdr_sop), .hdr_eop(hdr_eop), .hdr_empty(hdr_empty),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .pay_eop(pay_eop), .pay_empty(pay_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Builds input words (garbage 8'hEE in empty slots) and the expected output.
    task automatic build(input int hw, input int he, input int pw, input int pe,
                         input string tag);
        logic [7:0] all_s[$];
        word_t w;
        int n, nw;
        hq.delete();
        pq.delete();
        for (int k = 0; k < hw + pw; k++) begin
            bit is_hdr = (k < hw);
            bit last   = is_hdr ? (k == hw - 1) : (k == hw + pw - 1);
            int em     = last ? (is_hdr ? he : pe) : 0;
            w = '0;
            for (int s = 0; s < NSYM; s++) begin
                if (s < NSYM - em) begin
                    w.d[DATA_W-1-s*SYM_W -: SYM_W] = sym_ctr;
                    all_s.push_back(sym_ctr);
                    sym_ctr = sym_ctr + 8'd1;
                end else begin
                    w.d[DATA_W-1-s*SYM_W -: SYM_W] = 8'hEE;
                end
            end
            w.sop = is_hdr && (k == 0);
            w.eop = last;
            w.e   = EW'(em);
            if (is_hdr) hq.push_back(w); else pq.push_back(w);
        end
        n  = all_s.size();
        nw = (n + NSYM - 1) / NSYM;
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int s = 0; s < NSYM; s++)
                if (k*NSYM + s < n) w.d[DATA_W-1-s*SYM_W -: SYM_W] = all_s[k*NSYM + s];
            w.sop = (k == 0);
            w.eop = (k == nw - 1);
            w.e   = (k == nw - 1) ? EW'(nw*NSYM - n) : '0;
            exp_q.push_back(w);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drive_hdr();
        foreach (hq[i]) begin
            if (gap_on && ($urandom_range(0, 2) == 0)) begin
                @(negedge clk); hdr_valid = 1'b0;
            end
            @(negedge clk);
            hdr_valid = 1'b1; hdr_data = hq[i].d; hdr_sop = hq[i].sop;
            hdr_eop = hq[i].eop; hdr_empty = hq[i].e;
            forever begin
                #1;
                if (hdr_ready) begin @(posedge clk); break; end
                @(negedge clk);
            end
        end
        @(negedge clk); hdr_valid = 1'b0;
    endtask

    task automatic drive_pay();
        foreach (pq[i]) begin
            if (gap_on && ($urandom_range(0, 2) == 0)) begin
                @(negedge clk); pay_valid = 1'b0;
            end
            @(negedge clk);
            pay_valid = 1'b1; pay_data = pq[i].d;
            pay_eop = pq[i].eop; pay_empty = pq[i].e;
            forever begin
                #1;
                if (pay_ready) begin @(posedge clk); break; end
                @(negedge clk);
            end
        end
        @(negedge clk); pay_valid = 1'b0;
    endtask

    task automatic run_pkt(input int hw, input int he, input int pw, input int pe,
                           input string tag);
        build(hw, he, pw, pe, tag);
        fork
            drive_hdr();
            drive_pay();
        join
        for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
        check(exp_q.size() == 0, tag, "words still expected", 64'(exp_q.size()), 64'd0);
    endtask

    // Backpressure source
    initial forever begin
        @(negedge clk);
        out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // Monitor / scoreboard
    initial begin : monitor
        bit          stall_prev = 1'b0;
        logic [DATA_W-1:0] d_prev = '0;
        word_t       e;
        string       tg;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                check(!(hdr_ready && pay_ready), "R2", "both readies high",
                      {hdr_ready, pay_ready}, 64'd0);
                if (!out_ready)
                    check(!hdr_ready && !pay_ready, "R7", "ready while stalled",
                          {hdr_ready, pay_ready}, 64'd0);
                if (stall_prev)
                    check(out_valid && out_data == d_prev, "R7", "stalled word changed",
                          64'(out_data), 64'(d_prev));
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected word", 64'(out_data), 64'd0);
                    end else begin
                        e  = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check(out_data == e.d, tg, "data", 64'(out_data), 64'(e.d));
                        check(out_sop == e.sop && out_eop == e.eop, tg, "sop/eop",
                              {out_sop, out_eop}, {e.sop, e.eop});
                        check(out_empty == e.e, tg, "empty", 64'(out_empty), 64'(e.e));
                    end
                end
                stall_prev = out_valid && !out_ready;
                d_prev     = out_data;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // R9 reset state
        check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
        check(pay_ready == 1'b0, "R9", "pay_ready after reset", 64'(pay_ready), 64'd0);
        check(hdr_ready == 1'b1, "R9", "hdr_ready after reset", 64'(hdr_ready), 64'd1);

        run_pkt(2, 0, 3, 0, "R1 R6");
        run_pkt(2, 0, 2, 3, "R6 R4 R8");
        run_pkt(2, 2, 3, 0, "R3 R5 R8");
        run_pkt(3, 1, 2, 3, "R3 R4");
        run_pkt(2, 3, 2, 2, "R3 R4 R8");
        run_pkt(1, 2, 1, 1, "R10 R5");
        run_pkt(1, 1, 3, 0, "R10 R3");
        run_pkt(1, 0, 1, 0, "R1 R6");

        bp_on = 1'b1;
        gap_on = 1'b1;
        for (int it = 0; it < 40; it++)
            run_pkt($urandom_range(1, 3), $urandom_range(0, NSYM-1),
                    $urandom_range(1, 4), $urandom_range(0, NSYM-1), "R7 R2 R3 R4 R5");
        bp_on = 1'b0;
        gap_on = 1'b0;
        repeat (4) @(negedge clk);
        report();
    end

endmodule